// File: doc/BRIEF.md
# Sector Reduction and Skewed-Axis Transform

This block takes one sample of a reference voltage vector for an (M+1)-level space-vector modulator. Each sample is a modulation index and a phase angle. The block folds the angle into the first sixty-degree sector and reports which sector it came from. It then projects the vector onto a pair of axes that are 60 degrees apart. On that grid every basic inverter vector sits at an integer point, and the grid runs from 0 to M along each axis. The downstream nearest-vector selection and dwell-time logic work directly on the two coordinates. They use the sector number to map their choice back to the real phase.

The projection does not evaluate sine at run time. Two coefficients per in-sector angle step come from a 256-entry read-only table. The modulation index is multiplied by each coefficient and by M. If the projected point lies beyond the outer hexagon edge, because the coordinate sum exceeds M, both coordinates are scaled back so that their sum is exactly M. This needs a division, and a small bit-serial divider performs it. While the divider runs, the block stalls its pipeline and drops its ready output.

Top module: `svx_grid_xform`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `in_ready` is 1, and `sector_o`, `vm_o` and `vn_o` are all 0.
- R2: `sector_o` equals floor(angle·6 / 2^16), a value 0..5. Angle 0 is at the m-axis, and the full 16-bit scale is one turn.
- R3: The table index is bits [15:8] of (angle·6 mod 2^16). Entry i holds Ka = round((cos θ − sin θ/√3)·2^15) and Kb = round((2/√3)·sin θ·2^15), with θ = i·(π/3)/256.
- R4: Before any clamp, vm = floor(mi·Ka·M / 2^18). Here mi is unsigned with 11 fractional bits, and vm has 8 fractional bits.
- R5: Before any clamp, vn = floor(mi·Kb·M / 2^18), in the same formats as R4.
- R6: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. When no clamp is needed, its result appears with a one-cycle `out_valid` pulse three rising edges later.
- R7: A clamp happens only when vm + vn > M·256. A sum exactly equal to M·256 is passed through unchanged.
- R8: When clamped, the outputs are vm' = floor(vm·M·256 / (vm+vn)) and vn' = M·256 − vm'. The sector is the sample's own sector.
- R9: `in_ready` is 0 while a clamp division is in progress. A sample offered while `in_ready` is 0 is ignored: it produces no output and does not alter any later output. Results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| angle_i | input | 16 | Phase, full scale = one turn |
| mi_i | input | 12 | Modulation index, 11 fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| sector_o | output | 3 | Sector 0..5 of the sample |
| vm_o | output | 16 | m-axis coordinate, 8 fractional bits |
| vn_o | output | 16 | n-axis coordinate, 8 fractional bits |

## Verification
The assertions assume that the product mi·M fits the output range without wrap, so that an unclamped coordinate never exceeds 16 bits. They also assume that `in_valid` is a plain level that the driver may change freely while `in_ready` is low. The stimulus keeps mi below 2.0 and M at its default. Random samples are offered on every cycle the bench chooses, including cycles when `in_ready` is low, and only handshaken samples are entered into the expected-result queue. Directed cases hit the sector thresholds, the last table entry, a zero index, and a sum that exactly equals M.

// File: rtl/svx_pkg.sv
package svx_pkg;
  localparam int unsigned SECTORS  = 6;
  localparam int unsigned SECT_W   = 3;
  localparam int unsigned IDX_W    = 8;
  localparam int unsigned COEF_W   = 16;
  localparam int unsigned COEF_FRAC = 15;

  typedef struct packed {
    logic [COEF_W-1:0] ka;
    logic [COEF_W-1:0] kb;
  } coef_pair_t;
endpackage

// File: rtl/svx_sector.sv
module svx_sector
  import svx_pkg::*;
#(
  parameter int unsigned PHASE_W = 16
) (
  input  logic [PHASE_W-1:0] angle,
  output logic [SECT_W-1:0]  sector,
  output logic [IDX_W-1:0]   idx
);
  localparam int unsigned T6_W = PHASE_W + 3;

  logic [SECTORS-1:1] above;
  logic [T6_W-1:0]    times6;

  // thresholds at ceil(j * full_scale / 6)
  for (genvar j = 1; j < SECTORS; j++) begin : g_thr
    localparam longint unsigned THR = ((longint'(j) << PHASE_W) + SECTORS - 1) / SECTORS;
    assign above[j] = ({1'b0, angle} >= (PHASE_W+1)'(THR));
  end

  always_comb begin
    sector = '0;
    for (int j = 1; j < SECTORS; j++) begin
      sector = sector + SECT_W'(above[j]);
    end
  end

  assign times6 = ({3'b000, angle} << 2) + ({3'b000, angle} << 1);
  assign idx = IDX_W'(times6[PHASE_W-1:0] >> (PHASE_W - IDX_W));

  // R2: comparator count agrees with the integer part of angle*6
  always_comb begin
    sector_match_chk: assert (sector == SECT_W'(times6 >> PHASE_W));
  end
endmodule

// File: rtl/svx_coef_rom.sv
module svx_coef_rom
  import svx_pkg::*;
(
  input  logic             clk,
  input  logic             en,
  input  logic [IDX_W-1:0] addr,
  output coef_pair_t       data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  coef_pair_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real th, sc, a, b;
      th = (real'(i) * 3.14159265358979323846 / 3.0) / real'(DEPTH);
      sc = real'(1 << COEF_FRAC);
      a  = ($cos(th) - $sin(th) / $sqrt(3.0)) * sc;
      b  = (2.0 / $sqrt(3.0)) * $sin(th) * sc;
      mem[i].ka = COEF_W'($rtoi(a + 0.5));
      mem[i].kb = COEF_W'($rtoi(b + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    if (en) data <= mem[addr];
  end
endmodule

// File: rtl/svx_project.sv
module svx_project
  import svx_pkg::*;
#(
  parameter int unsigned MI_W     = 12,
  parameter int unsigned MI_FRAC  = 11,
  parameter int unsigned M_STEPS  = 2,
  parameter int unsigned OUT_W    = 16,
  parameter int unsigned OUT_FRAC = 8
) (
  input  logic [MI_W-1:0]  mi,
  input  coef_pair_t       coef,
  output logic [OUT_W-1:0] vm,
  output logic [OUT_W-1:0] vn
);
  localparam int unsigned LVL_W  = $clog2(M_STEPS + 1);
  localparam int unsigned PROD_W = MI_W + COEF_W + LVL_W + OUT_W;
  localparam int unsigned SHIFT  = MI_FRAC + COEF_FRAC - OUT_FRAC;

  logic [PROD_W-1:0] prod_m, prod_n;

  assign prod_m = PROD_W'(mi) * PROD_W'(coef.ka) * PROD_W'(M_STEPS);
  assign prod_n = PROD_W'(mi) * PROD_W'(coef.kb) * PROD_W'(M_STEPS);
  assign vm = OUT_W'(prod_m >> SHIFT);
  assign vn = OUT_W'(prod_n >> SHIFT);
endmodule

// File: rtl/svx_serial_div.sv
module svx_serial_div #(
  parameter int unsigned NUM_W = 33,
  parameter int unsigned DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] dsr;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   trial;

  assign trial = {rem, quo[NUM_W-1]};
  assign done  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rem  <= '0;
      dsr  <= '0;
      cnt  <= '0;
      quo  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      rem  <= '0;
      dsr  <= den;
      cnt  <= CNT_W'(NUM_W);
      quo  <= num;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (trial >= {1'b0, dsr}) begin
          rem <= DEN_W'(trial - {1'b0, dsr});
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= DEN_W'(trial);
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
      end
    end
  end

  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  // R8
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst) busy |-> rem < dsr);
endmodule

// File: rtl/svx_grid_xform.sv
module svx_grid_xform
  import svx_pkg::*;
#(
  parameter int unsigned PHASE_W  = 16,
  parameter int unsigned MI_W     = 12,
  parameter int unsigned MI_FRAC  = 11,
  parameter int unsigned M_STEPS  = 2,
  parameter int unsigned OUT_W    = 16,
  parameter int unsigned OUT_FRAC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PHASE_W-1:0] angle_i,
  input  logic [MI_W-1:0]    mi_i,
  output logic               out_valid,
  output logic [SECT_W-1:0]  sector_o,
  output logic [OUT_W-1:0]   vm_o,
  output logic [OUT_W-1:0]   vn_o
);
  localparam int unsigned SUM_W = OUT_W + 1;
  localparam int unsigned NUM_W = OUT_W + SUM_W;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(M_STEPS << OUT_FRAC);

  logic adv;
  logic div_busy, div_done, div_start;
  logic [NUM_W-1:0] div_quo;

  // stage 1: sector fold
  logic [SECT_W-1:0] k_c;
  logic [IDX_W-1:0]  idx_c;
  logic              s1_v;
  logic [SECT_W-1:0] s1_k;
  logic [IDX_W-1:0]  s1_idx;
  logic [MI_W-1:0]   s1_mi;

  svx_sector #(.PHASE_W(PHASE_W)) u_sector (
    .angle (angle_i),
    .sector(k_c),
    .idx   (idx_c)
  );

  assign adv      = !div_busy;
  assign in_ready = !div_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_k   <= '0;
      s1_idx <= '0;
      s1_mi  <= '0;
    end else if (adv) begin
      s1_v   <= in_valid;
      s1_k   <= k_c;
      s1_idx <= idx_c;
      s1_mi  <= mi_i;
    end
  end

  // stage 2: table read
  coef_pair_t        coef;
  logic              s2_v;
  logic [SECT_W-1:0] s2_k;
  logic [MI_W-1:0]   s2_mi;

  svx_coef_rom u_rom (
    .clk (clk),
    .en  (adv),
    .addr(s1_idx),
    .data(coef)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v  <= 1'b0;
      s2_k  <= '0;
      s2_mi <= '0;
    end else if (adv) begin
      s2_v  <= s1_v;
      s2_k  <= s1_k;
      s2_mi <= s1_mi;
    end
  end

  // stage 3: projection
  logic [OUT_W-1:0]  vm_c, vn_c;
  logic              s3_v;
  logic [SECT_W-1:0] s3_k;
  logic [OUT_W-1:0]  s3_vm, s3_vn;
  logic [SUM_W-1:0]  s3_sum;
  logic              s3_over;

  svx_project #(
    .MI_W(MI_W), .MI_FRAC(MI_FRAC), .M_STEPS(M_STEPS),
    .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
  ) u_proj (
    .mi  (s2_mi),
    .coef(coef),
    .vm  (vm_c),
    .vn  (vn_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_v  <= 1'b0;
      s3_k  <= '0;
      s3_vm <= '0;
      s3_vn <= '0;
    end else if (adv) begin
      s3_v  <= s2_v;
      s3_k  <= s2_k;
      s3_vm <= vm_c;
      s3_vn <= vn_c;
    end
  end

  assign s3_sum  = {1'b0, s3_vm} + {1'b0, s3_vn};
  assign s3_over = s3_sum > LIMIT;

  // clamp divider
  assign div_start = adv && s3_v && s3_over;

  svx_serial_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(div_start),
    .num  (NUM_W'(s3_vm) * NUM_W'(LIMIT)),
    .den  (s3_sum),
    .busy (div_busy),
    .done (div_done),
    .quo  (div_quo)
  );

  logic [SECT_W-1:0] pend_k;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_k <= '0;
    end else if (div_start) begin
      pend_k <= s3_k;
    end
  end

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sector_o  <= '0;
      vm_o      <= '0;
      vn_o      <= '0;
    end else if (div_done) begin
      out_valid <= 1'b1;
      sector_o  <= pend_k;
      vm_o      <= OUT_W'(div_quo);
      vn_o      <= OUT_W'(LIMIT - SUM_W'(div_quo));
    end else if (adv) begin
      out_valid <= s3_v && !s3_over;
      if (s3_v && !s3_over) begin
        sector_o <= s3_k;
        vm_o     <= s3_vm;
        vn_o     <= s3_vn;
      end
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R2
  sector_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sector_o < SECT_W'(SECTORS));
  // R7
  sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, vm_o} + {1'b0, vn_o}) <= LIMIT);
  // R8
  clamp_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(div_busy) |-> out_valid && (({1'b0, vm_o} + {1'b0, vn_o}) == LIMIT));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |=> $stable(s1_v) && $stable(s1_idx) && $stable(s1_mi));
  // R6
  pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) && !$past(div_busy) |-> $past(s3_v));
endmodule

// File: tb/svx_grid_xform_tb_top.sv
module svx_grid_xform_tb_top;
  localparam int M   = 2;
  localparam int LIM = M * 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] angle_i = '0;
  logic [11:0] mi_i = '0;
  logic out_valid;
  logic [2:0] sector_o;
  logic [15:0] vm_o, vn_o;

  always #10 clk = ~clk;

  svx_grid_xform dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .angle_i(angle_i), .mi_i(mi_i), .out_valid(out_valid),
    .sector_o(sector_o), .vm_o(vm_o), .vn_o(vn_o)
  );

  typedef struct packed {
    logic [2:0]  k;
    logic [15:0] vm;
    logic [15:0] vn;
    logic        over;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int produced = 0;
  bit done_run = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input int ang, input int mi);
    exp_t e;
    longint t6, frac, idx, ka, kb, vm, vn, sum, q;
    real th, sc;
    t6   = longint'(ang) * 6;
    e.k  = 3'(t6 >> 16);
    frac = t6 & 64'hFFFF;
    idx  = frac >> 8;
    th   = (real'(idx) * 3.14159265358979323846 / 3.0) / 256.0;
    sc   = 32768.0;
    ka   = longint'($rtoi(($cos(th) - $sin(th) / $sqrt(3.0)) * sc + 0.5));
    kb   = longint'($rtoi((2.0 / $sqrt(3.0)) * $sin(th) * sc + 0.5));
    vm   = (longint'(mi) * ka * M) >> 18;
    vn   = (longint'(mi) * kb * M) >> 18;
    sum  = vm + vn;
    e.over = (sum > LIM);
    if (e.over) begin
      q  = (vm * LIM) / sum;
      vm = q;
      vn = LIM - q;
    end
    e.vm = 16'(vm);
    e.vn = 16'(vn);
    return e;
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      produced++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected output", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(sector_o == e.k, "R2 sector", sector_o, e.k);
        chk(vm_o == e.vm, e.over ? "R8 vm clamp" : "R4 vm", vm_o, e.vm);
        chk(vn_o == e.vn, e.over ? "R8 vn clamp" : "R5 vn", vn_o, e.vn);
      end
    end
  end

  // offer one sample until it is taken
  task automatic send(input int ang, input int mi);
    bit taken = 1'b0;
    while (!taken) begin
      @(negedge clk);
      in_valid = 1'b1;
      angle_i  = 16'(ang);
      mi_i     = 12'(mi);
      if (in_ready) begin
        exp_q.push_back(model(ang, mi));
        accepted++;
        taken = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || !in_ready) && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EC7_0A11);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(vm_o == 0 && vn_o == 0 && sector_o == 0, "R1 outputs zero", {sector_o, vm_o, vn_o}, 0);

    // R6 latency: accepted at the next edge, visible after the third edge after it
    in_valid = 1'b1; angle_i = 16'd3000; mi_i = 12'd1024;
    exp_q.push_back(model(3000, 1024)); accepted++;
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 cycle1", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 cycle2", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 cycle3", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 cycle4 pulse", out_valid, 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 pulse one cycle", out_valid, 0);

    // R7 boundary: angle 0, mi 1.0 gives sum exactly M, no clamp
    send(0, 2048);
    drain();
    chk(vm_o == 16'(LIM) && vn_o == 0, "R7 sum equal to M unclamped", vm_o, LIM);
    // R2 / R3 thresholds and table ends
    send(10922, 1000);   // sector 0, index 255
    send(10923, 1000);   // sector 1, index 0
    send(65535, 1500);   // sector 5
    send(54614, 900);    // just above the sector 5 threshold
    send(0, 0);          // zero index, zero magnitude
    drain();
    // R8 clamp corner
    send(5000, 4095);
    drain();
    chk(in_ready == 1'b1, "R9 ready after clamp", in_ready, 1);

    // random phase: offers continue while in_ready is low (R9 ignored samples)
    for (int i = 0; i < 4000 && accepted < 400; i++) begin
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      angle_i  = 16'($urandom);
      mi_i     = (($urandom % 3) == 0) ? 12'($urandom) : 12'($urandom % 2048);
      if (in_valid && in_ready) begin
        exp_q.push_back(model(int'(angle_i), int'(mi_i)));
        accepted++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R9 results pending", exp_q.size(), 0);
    chk(produced == accepted, "R9 output count", produced, accepted);
    done_run = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_run) chk(1'b0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule